// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division for a processor core, one operation at a time, over several clock cycles. Its results do not go back to the general register file. A dedicated result pair holds them instead. HI receives the upper half of a product or the remainder of a division. LO receives the lower half of a product or the quotient. Both registers can be read at any time through two output ports, which serve the core's move-from instructions. Either register can also be loaded directly with a move-to command.

Each command presents an operation code and two register operands. No command takes an immediate operand. Multiplication uses a shift-add engine and division uses a restoring divider. Both run for one iteration per data bit. The block raises `busy` while an operation is in flight, so the core can stall any move-from that would read a stale result. A move-to that arrives while the block is busy is kept aside. It is applied at the moment the result lands, so it is never overwritten by that result.

Top module: `muldiv_hilo`

## Requirements
- R1: After a synchronous reset, `hi_o` and `lo_o` are zero and `busy` is low.
- R2: When `busy` is low, `cmd_valid` with `cmd_op` 0, 1, 2 or 3 starts an operation. `busy` is high from the next cycle for exactly W+1 cycles, and the results appear in `hi_o`/`lo_o` when `busy` falls.
- R3: Code 0 (signed multiply) writes the full 2W-bit two's-complement product of `cmd_a` and `cmd_b`. The upper half goes to HI and the lower half to LO.
- R4: Code 1 (unsigned multiply) writes the 2W-bit unsigned product, with the upper half in HI and the lower half in LO.
- R5: Code 2 (signed divide) writes the quotient of `cmd_a` by `cmd_b` to LO and the remainder to HI. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R6: Code 3 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R7: A divide by zero, signed or unsigned, completes with normal timing and raises no fault. LO becomes all ones and HI becomes the dividend `cmd_a`.
- R8: When `busy` is low, code 4 loads `cmd_a` into HI and code 5 loads `cmd_a` into LO at the next edge. The other register is untouched and `busy` stays low. `hi_o` and `lo_o` always show the register contents.
- R9: While `busy` is high, HI and LO do not change. A code 4 or 5 command issued during that time is held and lands when the operation completes. It replaces the result for that register, and the last such command wins.
- R10: A code 0 to 3 command issued while `busy` is high is ignored. Codes 6 and 7 are ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (0 smul, 1 umul, 2 sdiv, 3 udiv, 4 load HI, 5 load LO) |
| cmd_a | input | W | First operand, dividend, or move-to data |
| cmd_b | input | W | Second operand or divisor |
| busy | output | 1 | Operation in flight; results not yet valid |
| hi_o | output | W | Current HI contents |
| lo_o | output | W | Current LO contents |

## Verification
The bench builds the unit at 8 bits and crosses a strided grid of operand values with all four arithmetic codes. The grid covers every sign combination, zero and all-ones operands, and a zero divisor. Separate corner runs use the most negative value against -1 and against itself, where a wrong sign fix-up or a lost carry in the magnitude path shows up. The signed and unsigned forms on the same operands separate the sign-handling errors from the iteration errors. Directed sequences issue moves while the block is idle and while it is busy, and issue arithmetic and unused codes during an operation. These tell a held-off move apart from one that applies at once or is lost.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_SMUL = 3'd0,
    OP_UMUL = 3'd1,
    OP_SDIV = 3'd2,
    OP_UDIV = 3'd3,
    OP_LDHI = 3'd4,
    OP_LDLO = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;
endpackage

// File: rtl/muldiv_mul_core.sv
// Unsigned shift-add multiplier: one partial-product bit per step.
module muldiv_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           start,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [W:0]     sum;

  always_comb begin
    sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (start) begin
      mcand_q <= mcand;
      prod_q  <= {{W{1'b0}}, mplier};
    end else if (step) begin
      prod_q  <= {sum, prod_q[W-1:1]};
    end
  end

  assign prod = prod_q;
endmodule

// File: rtl/muldiv_div_core.sv
// Unsigned restoring divider: one quotient bit per step.
module muldiv_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] dsr_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] rem_q;
  logic [W:0]   shifted;
  logic [W+1:0] diff;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (start) begin
      dsr_q <= divisor;
      quo_q <= dividend;
      rem_q <= '0;
    end else if (step) begin
      if (diff[W+1]) begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end else begin
        rem_q <= diff[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
endmodule

// File: rtl/muldiv_hilo_regs.sv
// The HI/LO result pair, with independent write enables.
module muldiv_hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_hi,
  input  logic         we_lo,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_lo,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (we_hi) hi_q <= d_hi;
      if (we_lo) lo_q <= d_lo;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);

  op_e            op;
  logic           accept, start_mul, start_div, signed_op;
  logic           a_neg, b_neg, step, finish;
  logic [W-1:0]   mag_a, mag_b;
  logic           mv_hi, mv_lo;

  logic           busy_q, is_div_q, neg_lo_q, neg_hi_q, dz_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   dvd_q;
  logic           pend_hi_v, pend_lo_v;
  logic [W-1:0]   pend_hi_d, pend_lo_d;

  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0]   quo, rem;
  logic [W-1:0]   res_hi, res_lo;
  logic           we_hi, we_lo;
  logic [W-1:0]   d_hi, d_lo;

  always_comb begin
    op        = op_e'(cmd_op);
    accept    = cmd_valid && !busy_q;
    start_mul = accept && (op == OP_SMUL || op == OP_UMUL);
    start_div = accept && (op == OP_SDIV || op == OP_UDIV);
    signed_op = (op == OP_SMUL || op == OP_SDIV);
    a_neg     = signed_op && cmd_a[W-1];
    b_neg     = signed_op && cmd_b[W-1];
    mag_a     = a_neg ? (W'(0) - cmd_a) : cmd_a;
    mag_b     = b_neg ? (W'(0) - cmd_b) : cmd_b;
    step      = busy_q && (cnt_q != '0);
    finish    = busy_q && (cnt_q == '0);
    mv_hi     = cmd_valid && (op == OP_LDHI);
    mv_lo     = cmd_valid && (op == OP_LDLO);
  end

  // Sequencing: W iteration cycles followed by one write-back cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_mul || start_div) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(W);
    end else if (step) begin
      cnt_q  <= cnt_q - 1'b1;
    end else if (finish) begin
      busy_q <= 1'b0;
    end
  end

  // Per-operation context captured at acceptance.
  always_ff @(posedge clk) begin
    if (start_mul || start_div) begin
      is_div_q <= start_div;
      neg_lo_q <= a_neg ^ b_neg;
      neg_hi_q <= start_div ? a_neg : (a_neg ^ b_neg);
      dz_q     <= start_div && (cmd_b == '0);
      dvd_q    <= cmd_a;
    end
  end

  // Moves arriving mid-operation are parked until write-back.
  always_ff @(posedge clk) begin
    if (rst || finish) begin
      pend_hi_v <= 1'b0;
      pend_lo_v <= 1'b0;
    end else if (busy_q) begin
      if (mv_hi) begin
        pend_hi_v <= 1'b1;
        pend_hi_d <= cmd_a;
      end
      if (mv_lo) begin
        pend_lo_v <= 1'b1;
        pend_lo_d <= cmd_a;
      end
    end
  end

  muldiv_mul_core #(.W(W)) mul_i (
    .clk(clk), .start(start_mul), .step(step),
    .mcand(mag_a), .mplier(mag_b), .prod(prod)
  );

  muldiv_div_core #(.W(W)) div_i (
    .clk(clk), .start(start_div), .step(step),
    .dividend(mag_a), .divisor(mag_b), .quo(quo), .rem(rem)
  );

  always_comb begin
    prod_fix = neg_lo_q ? ((2*W)'(0) - prod) : prod;
    if (!is_div_q) begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end else if (dz_q) begin
      res_hi = dvd_q;
      res_lo = '1;
    end else begin
      res_hi = neg_hi_q ? (W'(0) - rem) : rem;
      res_lo = neg_lo_q ? (W'(0) - quo) : quo;
    end
  end

  always_comb begin
    we_hi = finish || (accept && mv_hi);
    we_lo = finish || (accept && mv_lo);
    if (finish) begin
      d_hi = mv_hi ? cmd_a : (pend_hi_v ? pend_hi_d : res_hi);
      d_lo = mv_lo ? cmd_a : (pend_lo_v ? pend_lo_d : res_lo);
    end else begin
      d_hi = cmd_a;
      d_lo = cmd_a;
    end
  end

  muldiv_hilo_regs #(.W(W)) regs_i (
    .clk(clk), .rst(rst), .we_hi(we_hi), .we_lo(we_lo),
    .d_hi(d_hi), .d_lo(d_lo), .hi_q(hi_o), .lo_q(lo_o)
  );

  assign busy = busy_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] cmd_a,
  input logic         busy,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  logic [15:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else              bcnt <= bcnt + 1'b1;
  end

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!busy && hi_o == '0 && lo_o == '0));

  // R2
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op < 3'd4) |=> busy);

  // R2
  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == 16'(W + 1)));

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(hi_o) && $stable(lo_o)));

  // R8
  p_move_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op == 3'd4) |=>
      (hi_o == $past(cmd_a) && $stable(lo_o) && !busy));

  // R8
  p_move_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op == 3'd5) |=>
      (lo_o == $past(cmd_a) && $stable(hi_o) && !busy));

  // R10
  p_unused_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd_op[2:1] == 2'b11) |=>
      (!busy && $stable(hi_o) && $stable(lo_o)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_a(cmd_a), .busy(busy), .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/muldiv_hilo_tb_top.sv
`timescale 1ns/1ps
module muldiv_hilo_tb_top;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = 3'd0;
  logic [W-1:0] cmd_a = '0;
  logic [W-1:0] cmd_b = '0;
  logic         busy;
  logic [W-1:0] hi_o, lo_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  muldiv_hilo #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - M : int'(v);
  endfunction

  task automatic issue(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_arith(input logic [2:0] op, input logic [W-1:0] a,
                           input logic [W-1:0] b);
    int cyc, ehi, elo, p, q, r;
    string tag;
    issue(op, a, b);
    wait_idle(cyc);
    check("R2 latency", cyc, W + 1);
    case (op)
      3'd0: begin p = sx(a) * sx(b); ehi = (p >> W) & (M-1); elo = p & (M-1); tag = "R3"; end
      3'd1: begin p = int'(a) * int'(b); ehi = (p >> W) & (M-1); elo = p & (M-1); tag = "R4"; end
      3'd2: begin
        if (b == 0) begin ehi = int'(a); elo = M-1; tag = "R7 sdiv0"; end
        else begin q = sx(a) / sx(b); r = sx(a) % sx(b);
          ehi = r & (M-1); elo = q & (M-1); tag = "R5"; end
      end
      default: begin
        if (b == 0) begin ehi = int'(a); elo = M-1; tag = "R7 udiv0"; end
        else begin ehi = int'(a) % int'(b); elo = int'(a) / int'(b); tag = "R6"; end
      end
    endcase
    check({tag, " hi"}, int'(hi_o), ehi);
    check({tag, " lo"}, int'(lo_o), elo);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 hi", int'(hi_o), 0);
    check("R1 lo", int'(lo_o), 0);
    check("R1 busy", int'(busy), 0);

    // R8: moves while idle
    issue(3'd4, 8'h5A, 8'h00);
    check("R8 hi", int'(hi_o), 'h5A);
    check("R8 lo untouched", int'(lo_o), 0);
    check("R8 busy", int'(busy), 0);
    issue(3'd5, 8'hC3, 8'h00);
    check("R8 lo", int'(lo_o), 'hC3);
    check("R8 hi untouched", int'(hi_o), 'h5A);

    // R10: unused codes when idle
    issue(3'd6, 8'h11, 8'h22);
    issue(3'd7, 8'h33, 8'h44);
    check("R10 busy", int'(busy), 0);
    check("R10 hi", int'(hi_o), 'h5A);
    check("R10 lo", int'(lo_o), 'hC3);

    // R9: move issued during operation is held off
    issue(3'd1, 8'd3, 8'd5);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_a = 8'hAA;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 hold hi", int'(hi_o), 'h5A);
    check("R9 hold lo", int'(lo_o), 'hC3);
    check("R9 busy", int'(busy), 1);
    wait_idle(cyc);
    check("R9 pend hi", int'(hi_o), 'hAA);
    check("R9 result lo", int'(lo_o), 15);

    // R10: arithmetic while busy is dropped
    issue(3'd1, 8'd2, 8'd3);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_a = 8'd100; cmd_b = 8'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle(cyc);
    check("R10 ignored hi", int'(hi_o), 0);
    check("R10 ignored lo", int'(lo_o), 6);
    check("R10 no restart", int'(busy), 0);

    // R5/R3 corners with the most negative value
    run_arith(3'd2, 8'h80, 8'hFF);
    run_arith(3'd2, 8'h80, 8'h80);
    run_arith(3'd0, 8'h80, 8'h80);
    run_arith(3'd0, 8'h80, 8'hFF);
    run_arith(3'd2, 8'h85, 8'h00);
    run_arith(3'd3, 8'hFF, 8'h00);
    run_arith(3'd2, 8'h7F, 8'h80);
    run_arith(3'd1, 8'hFF, 8'hFF);

    // R3 R4 R5 R6 R7: strided sweep of all four arithmetic codes
    for (int a = 0; a < M; a += 7) begin
      for (int b = 0; b < M; b += 5) begin
        for (int op = 0; op < 4; op++) begin
          run_arith(3'(op), W'(a), W'(b));
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule